// File: doc/BRIEF.md
# Digital I/O Event Interrupt Unit

This block turns activity on digital input lines into interrupt requests. Three kinds of event are watched. Each of a number of port groups has two candidate lines that can be used alone or together as an edge-triggered source, with the active edge chosen per group. One data port is compared, on the bits software selects, against a stored pattern. A second data port is watched on selected bits for any transition. Every event sets its own sticky flag. Software clears a flag by writing a 1 to it. A single registered request line carries the OR of all flags whose source is enabled.

All monitored inputs pass through two-flop synchronisers first, so the lines may be asynchronous to the block clock. Software reaches the unit through a small register bus. Writes are single-cycle and addressed. The read data is registered and follows the address one cycle later. There is one control register per group, followed by the pattern value, the pattern bit-enable and the change bit-enable registers.

Top module: `irq_unit`

## Requirements
- R1: After a synchronous reset every register reads 0, no flag is set and `irq` is 0.
- R2: Control register g (address g) bit 0 chooses the active edge of group g's selected signal (0 rising, 1 falling). When that edge occurs, group flag bit 1 is set.
- R3: Control bits [5:4] choose group g's source: 0 off (the flag never sets), 1 line A, 2 line B, 3 line A AND line B.
- R4: With control register 0 bit 6 set, control register 0 bit 2 is set when the pattern port, compared only on the bits set in the pattern enable register (address G+1), becomes equal to the pattern value register (address G). Bits not enabled never affect the result. An all-zero enable never fires.
- R5: The pattern flag is not set again while an equality persists. It needs a new not-equal to equal transition.
- R6: With control register 0 bit 7 set, control register 0 bit 3 is set when any bit of the change port that is enabled in the change enable register (address G+2) toggles. Toggles on bits not enabled are ignored.
- R7: Flags are sticky. Writing a 1 to a flag bit clears it and writing 0 leaves it. An event in the same cycle as a clear write leaves the flag set.
- R8: `irq` is the registered OR of each set flag whose source is enabled. Disabling a source masks its flag from `irq` without clearing it, and enabling it again brings the request back.
- R9: An input edge that sets a flag raises `irq` on the fourth rising clock edge after the input changes: two synchroniser stages, the flag register and the request register.
- R10: `bus_rdata` shows the register at the address presented one cycle earlier. The pattern and enable registers read back as written, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | $clog2(G+3) | Register address for read and write |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Registered read data |
| line_a | input | G | Candidate source line A per group |
| line_b | input | G | Candidate source line B per group |
| port_pat | input | W | Port compared against the pattern |
| port_cos | input | W | Port watched for changes |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong edge history register or source mux shows up as a group flag bit that is set or missing when the register is read back, within four cycles of the input change. A pattern comparator that loses its previous-match state either misses a fire or refires after a clear, and this is visible on the next read. A faulty request OR shows up on `irq` one cycle after the flags or enables change. The bench sweeps every source, edge and start/end level pair for every group, and drives varied pattern and mask values through both data-port detectors.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int CTL_EDGE    = 0;
  localparam int CTL_GFLAG   = 1;
  localparam int CTL_PMFLAG  = 2;
  localparam int CTL_COSFLAG = 3;
  localparam int CTL_SRC_LO  = 4;
  localparam int CTL_PMEN    = 6;
  localparam int CTL_COSEN   = 7;

  typedef enum logic [1:0] {
    SRC_OFF = 2'd0,
    SRC_A   = 2'd1,
    SRC_B   = 2'd2,
    SRC_AB  = 2'd3
  } src_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/irq_edge_grp.sv
module irq_edge_grp
  import irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     a,
  input  logic     b,
  input  src_sel_e src,
  input  logic     fall,
  input  logic     clr,
  output logic     flag
);
  logic sel, sel_q, ev;

  always_comb begin
    case (src)
      SRC_A:   sel = a;
      SRC_B:   sel = b;
      SRC_AB:  sel = a & b;
      default: sel = 1'b0;
    endcase
  end

  assign ev = (src != SRC_OFF) && (fall ? (sel_q && !sel) : (!sel_q && sel));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      flag  <= 1'b0;
    end else begin
      sel_q <= sel;
      flag  <= (flag && !clr) || ev;
    end
  end

  // R2
  grp_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !$past(flag)) |-> $past(ev));

  // R3
  grp_src_off_chk: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_OFF && !flag) |=> !flag);
endmodule

// File: rtl/irq_pattern.sv
module irq_pattern #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic [W-1:0] pat,
  input  logic [W-1:0] mask,
  input  logic         en,
  input  logic         clr,
  output logic         flag
);
  logic match, match_q, ev;

  assign match = (mask != '0) && (((din ^ pat) & mask) == '0);
  assign ev    = en && match && !match_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= 1'b0;
      flag    <= 1'b0;
    end else begin
      match_q <= match;
      flag    <= (flag && !clr) || ev;
    end
  end

  // R4
  pm_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !$past(flag)) |-> $past(match));

  // R5
  pm_persist_chk: assert property (@(posedge clk) disable iff (rst)
    (!flag && match && $past(match)) |=> !flag);
endmodule

// File: rtl/irq_cos.sv
module irq_cos #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic [W-1:0] mask,
  input  logic         en,
  input  logic         clr,
  output logic         flag
);
  logic [W-1:0] prev;
  logic         ev;

  assign ev = en && (((din ^ prev) & mask) != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '0;
      flag <= 1'b0;
    end else begin
      prev <= din;
      flag <= (flag && !clr) || ev;
    end
  end

  // R6
  cos_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !$past(flag)) |-> ((($past(din) ^ $past(prev)) & $past(mask)) != '0));
endmodule

// File: rtl/irq_unit.sv
module irq_unit
  import irq_pkg::*;
#(
  parameter int G  = 4,
  parameter int W  = 8,
  localparam int AW = $clog2(G + 3)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [G-1:0]  line_a,
  input  logic [G-1:0]  line_b,
  input  logic [W-1:0]  port_pat,
  input  logic [W-1:0]  port_cos,
  output logic          irq
);
  localparam int SW = 2 * G + 2 * W;
  localparam logic [AW-1:0] A_PAT  = AW'(G);
  localparam logic [AW-1:0] A_PMSK = AW'(G + 1);
  localparam logic [AW-1:0] A_CMSK = AW'(G + 2);

  logic [G-1:0] edge_fall;
  src_sel_e     src_q [G];
  logic         pm_en, cos_en;
  logic [W-1:0] pat_val, pat_msk, cos_msk;

  logic [SW-1:0] s_all;
  logic [G-1:0]  a_s, b_s;
  logic [W-1:0]  pat_s, cos_s;
  logic [G-1:0]  gflag, gclr, gon;
  logic          pm_flag, cos_flag, pm_clr, cos_clr;
  logic [W-1:0]  rd_next;

  irq_sync #(.W(SW)) u_sync (
    .clk(clk), .rst(rst),
    .d({line_a, line_b, port_pat, port_cos}),
    .q(s_all)
  );
  assign {a_s, b_s, pat_s, cos_s} = s_all;

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_fall <= '0;
      pm_en     <= 1'b0;
      cos_en    <= 1'b0;
      pat_val   <= '0;
      pat_msk   <= '0;
      cos_msk   <= '0;
      for (int g = 0; g < G; g++) src_q[g] <= SRC_OFF;
    end else if (bus_we) begin
      for (int g = 0; g < G; g++) begin
        if (bus_addr == AW'(g)) begin
          edge_fall[g] <= bus_wdata[CTL_EDGE];
          src_q[g]     <= src_sel_e'(bus_wdata[CTL_SRC_LO +: 2]);
          if (g == 0) begin
            pm_en  <= bus_wdata[CTL_PMEN];
            cos_en <= bus_wdata[CTL_COSEN];
          end
        end
      end
      if (bus_addr == A_PAT)  pat_val <= bus_wdata;
      if (bus_addr == A_PMSK) pat_msk <= bus_wdata;
      if (bus_addr == A_CMSK) cos_msk <= bus_wdata;
    end
  end

  for (genvar gi = 0; gi < G; gi++) begin : g_grp
    assign gclr[gi] = bus_we && (bus_addr == AW'(gi)) && bus_wdata[CTL_GFLAG];
    assign gon[gi]  = gflag[gi] && (src_q[gi] != SRC_OFF);
    irq_edge_grp u_grp (
      .clk(clk), .rst(rst),
      .a(a_s[gi]), .b(b_s[gi]),
      .src(src_q[gi]), .fall(edge_fall[gi]),
      .clr(gclr[gi]), .flag(gflag[gi])
    );
  end

  assign pm_clr  = bus_we && (bus_addr == '0) && bus_wdata[CTL_PMFLAG];
  assign cos_clr = bus_we && (bus_addr == '0) && bus_wdata[CTL_COSFLAG];

  irq_pattern #(.W(W)) u_pat (
    .clk(clk), .rst(rst), .din(pat_s), .pat(pat_val), .mask(pat_msk),
    .en(pm_en), .clr(pm_clr), .flag(pm_flag)
  );

  irq_cos #(.W(W)) u_cos (
    .clk(clk), .rst(rst), .din(cos_s), .mask(cos_msk),
    .en(cos_en), .clr(cos_clr), .flag(cos_flag)
  );

  always_comb begin
    rd_next = '0;
    for (int g = 0; g < G; g++) begin
      if (bus_addr == AW'(g)) begin
        rd_next[CTL_EDGE]        = edge_fall[g];
        rd_next[CTL_GFLAG]       = gflag[g];
        rd_next[CTL_SRC_LO +: 2] = src_q[g];
        if (g == 0) begin
          rd_next[CTL_PMFLAG]  = pm_flag;
          rd_next[CTL_COSFLAG] = cos_flag;
          rd_next[CTL_PMEN]    = pm_en;
          rd_next[CTL_COSEN]   = cos_en;
        end
      end
    end
    if (bus_addr == A_PAT)  rd_next = pat_val;
    if (bus_addr == A_PMSK) rd_next = pat_msk;
    if (bus_addr == A_CMSK) rd_next = cos_msk;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= rd_next;
      irq       <= (|gon) || (pm_flag && pm_en) || (cos_flag && cos_en);
    end
  end

  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past((|gflag) || pm_flag || cos_flag));

  // R10
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) > A_CMSK) |-> (bus_rdata == '0));
endmodule

// File: tb/test_irq_unit.sv
module test_irq_unit;
  localparam int G  = 4;
  localparam int W  = 8;
  localparam int AW = $clog2(G + 3);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic [G-1:0]  line_a = '0;
  logic [G-1:0]  line_b = '0;
  logic [W-1:0]  port_pat = '0;
  logic [W-1:0]  port_cos = '0;
  logic          irq;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] rd_val;

  always #2.5 clk = ~clk;

  irq_unit #(.G(G), .W(W)) i_irq_unit (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_a(line_a),
    .line_b(line_b), .port_pat(port_pat), .port_cos(port_cos), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    bus_addr  = AW'(a);
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input int a);
    bus_addr = AW'(a);
    @(negedge clk);
    rd_val = bus_rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  function automatic logic srcval(input int s, input logic [1:0] ab);
    case (s)
      1: return ab[0];
      2: return ab[1];
      3: return ab[0] & ab[1];
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state of every address and of irq
    chk("R1 irq", {7'b0, irq}, 8'h00);
    for (int a = 0; a < 8; a++) begin
      rd(a);
      chk("R1 reg", rd_val, 8'h00);
    end

    // R2 R3: every group, source, edge and start/end level pair
    for (int g = 0; g < G; g++)
      for (int s = 0; s < 4; s++)
        for (int e = 0; e < 2; e++)
          for (int st = 0; st < 4; st++)
            for (int en = 0; en < 4; en++) begin
              logic fs, fe, exp;
              logic [7:0] cfg;
              cfg = {2'b00, 2'(s), 2'b00, 1'b1, 1'(e)};
              wr(g, cfg);
              line_a[g] = st[0];
              line_b[g] = st[1];
              settle();
              wr(g, cfg);
              line_a[g] = en[0];
              line_b[g] = en[1];
              settle();
              rd(g);
              fs  = srcval(s, 2'(st));
              fe  = srcval(s, 2'(en));
              exp = e ? (fs & !fe) : (!fs & fe);
              chk(s == 0 ? "R3 source off" : "R2 edge flag", {7'b0, rd_val[1]}, {7'b0, exp});
            end
    line_a = '0;
    line_b = '0;
    for (int g = 0; g < G; g++) wr(g, 8'h02);
    settle();

    // R4 R5: pattern match over varied values and masks
    wr(0, 8'h40);
    for (int i = 0; i < 64; i++) begin
      logic [7:0] pat, msk, din;
      logic exp;
      pat = 8'(i * 37);
      msk = 8'(i * 53) ^ 8'h5a;
      din = (i % 2 == 1) ? ((pat & msk) | (~msk & 8'(i * 11))) : 8'(i * 91);
      wr(G, pat);
      wr(G + 1, msk);
      port_pat = pat ^ msk;
      settle();
      wr(0, 8'h44);
      port_pat = din;
      settle();
      rd(0);
      exp = (msk != 0) && (((din ^ pat) & msk) == 0);
      chk("R4 pattern match", {7'b0, rd_val[2]}, {7'b0, exp});
      if (exp) begin
        wr(0, 8'h44);
        settle();
        rd(0);
        chk("R5 no retrigger", {7'b0, rd_val[2]}, 8'h00);
      end
    end
    // R10: pattern registers read back
    rd(G);
    chk("R10 pattern readback", rd_val, 8'(63 * 37));
    rd(G + 1);
    chk("R10 enable readback", rd_val, 8'(63 * 53) ^ 8'h5a);
    rd(7);
    chk("R10 unmapped", rd_val, 8'h00);
    wr(0, 8'h04);

    // R6: change of state on masked bits
    wr(0, 8'h80);
    for (int i = 0; i < 64; i++) begin
      logic [7:0] msk, a0, a1;
      logic exp;
      msk = 8'(i * 29);
      a0  = 8'(i * 71);
      a1  = a0 ^ 8'(i * 13);
      wr(G + 2, msk);
      port_cos = a0;
      settle();
      wr(0, 8'h88);
      port_cos = a1;
      settle();
      rd(0);
      exp = ((a0 ^ a1) & msk) != 0;
      chk("R6 change of state", {7'b0, rd_val[3]}, {7'b0, exp});
    end

    // R8: enable masks a set flag without clearing it
    wr(0, 8'h88);
    wr(G + 2, 8'hff);
    port_cos = port_cos ^ 8'h01;
    settle();
    chk("R8 irq on cos", {7'b0, irq}, 8'h01);
    wr(0, 8'h00);
    @(negedge clk);
    chk("R8 irq masked", {7'b0, irq}, 8'h00);
    rd(0);
    chk("R8 flag kept", {7'b0, rd_val[3]}, 8'h01);
    wr(0, 8'h80);
    @(negedge clk);
    chk("R8 irq restored", {7'b0, irq}, 8'h01);
    wr(0, 8'h88);
    @(negedge clk);
    chk("R7 cleared irq", {7'b0, irq}, 8'h00);
    wr(0, 8'h00);

    // R9: latency from input to irq, group 1 line A rising
    wr(1, 8'h12);
    settle();
    line_a[1] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 irq not yet", {7'b0, irq}, 8'h00);
    @(negedge clk);
    chk("R9 irq at fourth edge", {7'b0, irq}, 8'h01);
    // R7: writing 0 leaves the flag
    wr(1, 8'h10);
    rd(1);
    chk("R7 write 0 keeps", {7'b0, rd_val[1]}, 8'h01);
    wr(1, 8'h12);
    rd(1);
    chk("R7 write 1 clears", {7'b0, rd_val[1]}, 8'h00);

    // R7: event and clear in the same cycle, group 2
    wr(2, 8'h12);
    settle();
    line_a[2] = 1'b1;
    repeat (2) @(negedge clk);
    wr(2, 8'h12);
    rd(2);
    chk("R7 set wins over clear", {7'b0, rd_val[1]}, 8'h01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule